// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host end of a two-wire synchronous programming link. It produces a serial clock and controls a bidirectional data line through a separate output value and output enable. A controller sends it one transaction at a time over a valid/ready handshake. A transaction is a 4-bit command code followed by a 16-bit payload, for 20 serial clocks in all. The controller also sets flags that mark the transaction as a read, place a single byte into one half of the payload, or append a bulk-erase hold.

Both clock half-periods come from a programmable count of system cycles. Outgoing data changes together with the rising serial clock. Read data is captured when the serial clock falls. After a start-programming command (code 4'b1111), the fourth command clock of the next transaction is stretched: its high phase lasts the programming time and its low phase lasts the discharge time. All hold lengths are cycle counts taken from configuration inputs. The engine stays busy until each hold has run out.

Top module: `pls_host_seq`

## Requirements
- R1: Every accepted transaction produces exactly 20 serial clock pulses. The 4-bit command goes out first, least significant bit first, then the 16-bit payload, also least significant bit first. `pgd_out` changes only in the cycle where `pgc` rises, and it stays constant while `pgc` is high.
- R2: Outside the stretched clock, each high phase and each low phase of `pgc` lasts `cfg_half` system cycles. A value of 0 is treated as 1.
- R3: With `req_read` set, payload clocks 1 to 8 drive 0. The line is released (`pgd_oe`=0, `pgd_out`=0) in the cycle where the 8th payload clock falls. `pgc` then stays low for an extra `max(cfg_turn,1)` cycles, and the line remains released through the last 8 clocks.
- R4: For a read, `pgd_in` is sampled at each of the last 8 falling edges, least significant bit first. The byte appears on `rd_data` together with a one-cycle `rd_valid` pulse in the first cycle after the last low phase ends.
- R5: If the previously accepted transaction had command 4'b1111, the 4th command clock of this transaction stays high for `max(cfg_prog,1)` cycles and low for `max(cfg_dis,1)` cycles.
- R6: The programming stretch applies to only the one transaction that directly follows a 4'b1111 command. Reset cancels a pending stretch.
- R7: With `req_byte_mode` set, the payload sent is `{req_payload[7:0],8'h00}` when `req_byte_hi`=1, and `{8'h00,req_payload[7:0]}` otherwise.
- R8: With `req_erase` set, after the last low phase the engine holds `pgc`=0, `pgd_oe`=1 and `pgd_out`=0 for `max(cfg_erase+cfg_dis,1)` cycles, with `busy` high throughout.
- R9: `req_ready` is high exactly when the engine is idle, and `busy` is its inverse. Requests presented while busy have no effect on the line.
- R10: At reset and while idle, `pgc`, `pgd_oe`, `pgd_out` and `rd_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_cmd | input | 4 | Command code |
| req_payload | input | 16 | Write payload |
| req_read | input | 1 | Transaction returns a byte |
| req_byte_mode | input | 1 | Send only one byte of the payload |
| req_byte_hi | input | 1 | Byte mode: place the byte in the upper half |
| req_erase | input | 1 | Append a bulk-erase hold |
| cfg_half | input | DW | Serial clock half-period in cycles |
| cfg_prog | input | CW | Programming high time in cycles |
| cfg_dis | input | CW | Discharge low time in cycles |
| cfg_erase | input | CW | Erase time in cycles |
| cfg_turn | input | CW | Read turnaround time in cycles |
| pgc | output | 1 | Serial clock |
| pgd_out | output | 1 | Data line output value |
| pgd_oe | output | 1 | Data line output enable |
| pgd_in | input | 1 | Data line input value |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transaction or hold in progress |

## Verification
The bench builds the engine with its default widths (CW=16, DW=8). It drives small cycle counts: half-periods of 1 and 3, a programming time of 40, a discharge time of 7 and an erase time of 50. With these values every phase boundary, the turnaround gap and the stretched fourth clock each fit within a few hundred cycles. A zero turnaround setting exercises the minimum-length rule. The behavioural model expands every transaction into an expected per-cycle waveform and compares the line outputs, the handshake and the read strobe against it on every clock.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int unsigned CMD_W = 4;
    localparam int unsigned PAY_W = 16;
    localparam int unsigned RB_W  = 8;
    localparam logic [CMD_W-1:0] CMD_START_PGM = 4'b1111;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HIGH,
        S_LOW,
        S_TURN,
        S_ERASE
    } pls_state_e;
endpackage

// File: rtl/pls_frame_build.sv
module pls_frame_build
    import pls_pkg::*;
(
    input  logic [CMD_W-1:0]       cmd,
    input  logic [PAY_W-1:0]       payload,
    input  logic                   is_read,
    input  logic                   byte_mode,
    input  logic                   byte_hi,
    output logic [CMD_W+PAY_W-1:0] frame
);
    localparam int unsigned HW = PAY_W / 2;

    logic [PAY_W-1:0] pay_sel;

    always_comb begin
        if (is_read) begin
            pay_sel = '0;
        end else if (byte_mode) begin
            pay_sel = byte_hi ? {payload[HW-1:0], {HW{1'b0}}}
                              : {{HW{1'b0}}, payload[HW-1:0]};
        end else begin
            pay_sel = payload;
        end
        frame = {pay_sel, cmd};
    end
endmodule

// File: rtl/pls_rx_byte.sv
module pls_rx_byte #(
    parameter int unsigned W = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [IW-1:0] idx,
    input  logic          din,
    output logic [W-1:0]  q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = clr ? '0 : q_q;
        if (en) q_d[idx] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/pls_host_seq.sv
module pls_host_seq
    import pls_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic [PAY_W-1:0] req_payload,
    input  logic             req_read,
    input  logic             req_byte_mode,
    input  logic             req_byte_hi,
    input  logic             req_erase,
    input  logic [DW-1:0]    cfg_half,
    input  logic [CW-1:0]    cfg_prog,
    input  logic [CW-1:0]    cfg_dis,
    input  logic [CW-1:0]    cfg_erase,
    input  logic [CW-1:0]    cfg_turn,
    output logic             pgc,
    output logic             pgd_out,
    output logic             pgd_oe,
    input  logic             pgd_in,
    output logic [RB_W-1:0]  rd_data,
    output logic             rd_valid,
    output logic             busy
);
    localparam int unsigned NW    = CW + 1;
    localparam int unsigned FW    = CMD_W + PAY_W;
    localparam int unsigned BW    = $clog2(FW + 1);
    localparam int unsigned RB_IW = $clog2(RB_W);
    localparam logic [BW-1:0] HOLD_BIT = BW'(CMD_W - 1);
    localparam logic [BW-1:0] RD_REL   = BW'(FW - RB_W - 1);
    localparam logic [BW-1:0] RD_FIRST = BW'(FW - RB_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

    typedef logic [NW-1:0] cnt_t;

    typedef struct packed {
        pls_state_e     st;
        logic [BW-1:0]  bi;
        cnt_t           cnt;
        logic [FW-1:0]  fr;
        logic           rd;
        logic           er;
        logic           hold;
        logic           pend;
        logic           pgc;
        logic           dout;
        logic           oe;
        logic           rv;
    } seq_t;

    localparam seq_t SEQ_RST = '0;

    seq_t s_d, s_q;
    logic [FW-1:0]    frame_w;
    logic             rx_clr, rx_en;
    logic [RB_IW-1:0] rx_idx;
    cnt_t             half_c, prog_c, dis_c, erase_c, turn_c;
    logic             last;

    assign half_c  = cnt_t'(cfg_half);
    assign prog_c  = cnt_t'(cfg_prog);
    assign dis_c   = cnt_t'(cfg_dis);
    assign turn_c  = cnt_t'(cfg_turn);
    assign erase_c = cnt_t'(cfg_erase) + cnt_t'(cfg_dis);

    pls_frame_build u_frame (
        .cmd       (req_cmd),
        .payload   (req_payload),
        .is_read   (req_read),
        .byte_mode (req_byte_mode),
        .byte_hi   (req_byte_hi),
        .frame     (frame_w)
    );

    pls_rx_byte #(.W(RB_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .en    (rx_en),
        .idx   (rx_idx),
        .din   (pgd_in),
        .q     (rd_data)
    );

    // Start the high phase of serial clock n.
    function automatic seq_t rise_to(seq_t s, logic [BW-1:0] n, cnt_t hi_len, cnt_t pr_len);
        seq_t r;
        r      = s;
        r.st   = S_HIGH;
        r.bi   = n;
        r.pgc  = 1'b1;
        r.cnt  = (n == HOLD_BIT && s.hold) ? pr_len : hi_len;
        r.oe   = !(s.rd && n >= RD_FIRST);
        r.dout = r.oe & s.fr[n];
        return r;
    endfunction

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        rx_clr = 1'b0;
        rx_en  = 1'b0;
        rx_idx = RB_IW'(s_q.bi - RD_FIRST);
        last   = s_q.cnt <= cnt_t'(1);
        case (s_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    s_d.fr   = frame_w;
                    s_d.rd   = req_read;
                    s_d.er   = req_erase;
                    s_d.hold = s_q.pend;
                    s_d.pend = (req_cmd == CMD_START_PGM);
                    rx_clr   = 1'b1;
                    s_d      = rise_to(s_d, '0, half_c, prog_c);
                end
            end
            S_HIGH: begin
                if (!last) begin
                    s_d.cnt = s_q.cnt - cnt_t'(1);
                end else begin
                    s_d.st  = S_LOW;
                    s_d.pgc = 1'b0;
                    s_d.cnt = (s_q.bi == HOLD_BIT && s_q.hold) ? dis_c : half_c;
                    if (s_q.rd && s_q.bi >= RD_FIRST) rx_en = 1'b1;
                    if (s_q.rd && s_q.bi == RD_REL) begin
                        s_d.oe   = 1'b0;
                        s_d.dout = 1'b0;
                    end
                end
            end
            S_LOW: begin
                if (!last) begin
                    s_d.cnt = s_q.cnt - cnt_t'(1);
                end else if (s_q.bi == LAST_BIT) begin
                    s_d.rv   = s_q.rd;
                    s_d.dout = 1'b0;
                    if (s_q.er) begin
                        s_d.st  = S_ERASE;
                        s_d.cnt = erase_c;
                        s_d.oe  = 1'b1;
                    end else begin
                        s_d.st = S_IDLE;
                        s_d.oe = 1'b0;
                    end
                end else if (s_q.rd && s_q.bi == RD_REL) begin
                    s_d.st  = S_TURN;
                    s_d.cnt = turn_c;
                end else begin
                    s_d = rise_to(s_d, BW'(s_q.bi + 1'b1), half_c, prog_c);
                end
            end
            S_TURN: begin
                if (!last) s_d.cnt = s_q.cnt - cnt_t'(1);
                else       s_d = rise_to(s_d, RD_FIRST, half_c, prog_c);
            end
            S_ERASE: begin
                if (!last) begin
                    s_d.cnt = s_q.cnt - cnt_t'(1);
                end else begin
                    s_d.st   = S_IDLE;
                    s_d.oe   = 1'b0;
                    s_d.dout = 1'b0;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign pgc       = s_q.pgc;
    assign pgd_out   = s_q.dout;
    assign pgd_oe    = s_q.oe;
    assign rd_valid  = s_q.rv;
    assign busy      = (s_q.st != S_IDLE);
    assign req_ready = (s_q.st == S_IDLE);
endmodule

// File: rtl/pls_chk.sv
module pls_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic pgc,
    input logic pgd_out,
    input logic pgd_oe,
    input logic rd_valid
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!pgc && !pgd_oe && !pgd_out));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgc && $past(pgc)) |-> $stable(pgd_out));

    // R3
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgd_oe |-> !pgd_out);
endmodule

bind pls_host_seq pls_chk u_pls_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .pgc       (pgc),
    .pgd_out   (pgd_out),
    .pgd_oe    (pgd_oe),
    .rd_valid  (rd_valid)
);

// File: tb/test_pls_host_seq.sv
`timescale 1ns/1ps
module test_pls_host_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = '0;
    logic [15:0] req_payload = '0;
    logic        req_read = 1'b0, req_byte_mode = 1'b0, req_byte_hi = 1'b0, req_erase = 1'b0;
    logic [7:0]  cfg_half = 8'd1;
    logic [15:0] cfg_prog = 16'd1, cfg_dis = 16'd1, cfg_erase = 16'd1, cfg_turn = 16'd1;
    logic        pgc, pgd_out, pgd_oe;
    logic        pgd_in = 1'b1;
    logic [7:0]  rd_data;
    logic        rd_valid, busy;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit m_pend = 0;

    bit    q_pgc[$], q_oe[$], q_do[$], q_pin[$], q_rv[$];
    string q_tag[$];

    always #4 clk = ~clk;

    pls_host_seq i_pls_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_payload(req_payload), .req_read(req_read),
        .req_byte_mode(req_byte_mode), .req_byte_hi(req_byte_hi), .req_erase(req_erase),
        .cfg_half(cfg_half), .cfg_prog(cfg_prog), .cfg_dis(cfg_dis),
        .cfg_erase(cfg_erase), .cfg_turn(cfg_turn), .pgc(pgc), .pgd_out(pgd_out),
        .pgd_oe(pgd_oe), .pgd_in(pgd_in), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish (act=%0d exp<150000)", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic push(input bit p, input bit o, input bit d, input bit pin, input bit rv, input string tag);
        q_pgc.push_back(p); q_oe.push_back(o); q_do.push_back(d);
        q_pin.push_back(pin); q_rv.push_back(rv); q_tag.push_back(tag);
    endtask

    task automatic check_idle(input string tag, input bit exp_rv);
        int act, exp;
        act = {pgc, pgd_oe, pgd_out, rd_valid, req_ready, busy};
        exp = {1'b0, 1'b0, 1'b0, exp_rv, 1'b1, 1'b0};
        chk(act == exp, tag, "idle {pgc,oe,out,rv,rdy,busy}", act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; m_pend = 0;
        @(negedge clk);
        check_idle("R10", 1'b0);
    endtask

    task automatic run_txn(input logic [3:0] cmd, input logic [15:0] pay, input bit rd,
                           input bit bm, input bit bh, input bit er, input logic [7:0] tb,
                           input bit noise, input string base);
        logic [15:0] sent;
        logic [19:0] fr;
        bit hold, drv, ldrv, d, pin;
        int hl, ll;
        string tg;
        sent = rd ? 16'h0 : (bm ? (bh ? {pay[7:0], 8'h00} : {8'h00, pay[7:0]}) : pay);
        fr = {sent, cmd};
        hold = m_pend;
        m_pend = (cmd == 4'hF);
        for (int b = 0; b < 20; b++) begin
            drv  = !(rd && b >= 12);
            d    = drv ? fr[b] : 1'b0;
            pin  = (rd && b >= 12) ? tb[b-12] : 1'b1;
            tg   = (b == 3 && hold) ? "R5" : ((rd && b >= 11) ? "R3" : base);
            hl   = (b == 3 && hold) ? max1(int'(cfg_prog)) : max1(int'(cfg_half));
            ll   = (b == 3 && hold) ? max1(int'(cfg_dis))  : max1(int'(cfg_half));
            ldrv = drv && !(rd && b == 11);
            repeat (hl) push(1'b1, drv, d, pin, 1'b0, tg);
            repeat (ll) push(1'b0, ldrv, ldrv ? d : 1'b0, pin, 1'b0, tg);
            if (rd && b == 11) repeat (max1(int'(cfg_turn))) push(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
        end
        if (er) begin
            for (int k = 0; k < max1(int'(cfg_erase) + int'(cfg_dis)); k++)
                push(1'b0, 1'b1, 1'b0, 1'b1, (k == 0) ? rd : 1'b0, "R8");
        end
        req_cmd = cmd; req_payload = pay; req_read = rd; req_byte_mode = bm;
        req_byte_hi = bh; req_erase = er; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9", "ready before accept", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < q_pgc.size(); i++) begin
            int act, exp;
            act = {pgc, pgd_oe, pgd_out, rd_valid, req_ready, busy};
            exp = {q_pgc[i], q_oe[i], q_do[i], q_rv[i], 1'b0, 1'b1};
            chk(act == exp, q_tag[i], $sformatf("cycle %0d {pgc,oe,out,rv,rdy,busy}", i), act, exp);
            pgd_in = q_pin[i];
            if (noise && i >= 2 && i <= 5) begin
                req_valid = 1'b1; req_cmd = 4'hF; req_payload = 16'h0;
                req_read = 1'b0; req_erase = 1'b0; req_byte_mode = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        pgd_in = 1'b1;
        check_idle(noise ? "R9" : base, rd && !er);
        if (rd) chk(rd_data == tb, "R4", "read byte", int'(rd_data), int'(tb));
        q_pgc.delete(); q_oe.delete(); q_do.delete(); q_pin.delete(); q_rv.delete(); q_tag.delete();
        @(negedge clk);
        chk(rd_valid == 1'b0, "R4", "strobe after one cycle", int'(rd_valid), 0);
    endtask

    initial begin
        do_reset();
        cfg_half = 8'd1; cfg_turn = 16'd4; cfg_prog = 16'd40; cfg_dis = 16'd7; cfg_erase = 16'd50;
        run_txn(4'h0, 16'hA5C3, 0, 0, 0, 0, 8'h00, 0, "R1");
        cfg_half = 8'd3;
        run_txn(4'hD, 16'h1234, 0, 0, 0, 0, 8'h00, 0, "R2");
        cfg_half = 8'd0;
        run_txn(4'hC, 16'h8001, 0, 0, 0, 0, 8'h00, 0, "R2");
        cfg_half = 8'd2; cfg_turn = 16'd5;
        run_txn(4'h2, 16'hFFFF, 1, 0, 0, 0, 8'h6B, 0, "R3");
        cfg_turn = 16'd0;
        run_txn(4'h2, 16'h0000, 1, 0, 0, 0, 8'h94, 0, "R4");
        cfg_half = 8'd1;
        run_txn(4'hF, 16'hBE5A, 0, 1, 1, 0, 8'h00, 0, "R7");
        run_txn(4'h0, 16'h0F0F, 0, 0, 0, 0, 8'h00, 0, "R5");
        run_txn(4'h0, 16'h7777, 0, 0, 0, 0, 8'h00, 0, "R6");
        run_txn(4'hF, 16'hC33C, 0, 1, 0, 0, 8'h00, 0, "R7");
        cfg_turn = 16'd3;
        run_txn(4'h2, 16'h0000, 1, 0, 0, 0, 8'h81, 0, "R5");
        run_txn(4'h0, 16'h0000, 0, 0, 0, 1, 8'h00, 0, "R8");
        run_txn(4'hC, 16'hFFFF, 0, 0, 0, 0, 8'h00, 1, "R9");
        run_txn(4'hF, 16'h0102, 0, 0, 0, 0, 8'h00, 0, "R1");
        do_reset();
        run_txn(4'h0, 16'h5555, 0, 0, 0, 0, 8'h00, 0, "R6");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule